// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This unit sits between a 32-bit integer core and a word-wide, big-endian data memory. For a store it turns the core's source register into four per-byte write enables and a lane-aligned write word. For a load it takes the word the memory returned and picks out the addressed byte or halfword, zero-extending it to 32 bits, or passes a full word through unchanged. It handles unsigned byte loads, unsigned halfword loads and word loads, plus byte, halfword and word stores.

Address arithmetic happens upstream. The unit receives only the two low address bits, the byte offset inside the word, together with the access opcode. A halfword access at an odd offset is rejected, and so is a word access at an offset other than zero. A rejected load raises a load alignment fault and a rejected store raises a separate store alignment fault. Each fault comes with the matching exception code, and a faulted store drives no byte enables. All outputs are registered and appear one clock after the request is sampled.

Top module: `be_lane_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is zero.
- R2: Only six opcodes act when `req_valid` is high: 0x24 (byte load, unsigned), 0x25 (halfword load, unsigned), 0x23 (word load), 0x28 (byte store), 0x29 (halfword store) and 0x2b (word store). Any other opcode, or `req_valid` low, gives all-zero outputs.
- R3: Lanes are numbered big-endian. Byte offset 0 is bits 31:24 of the word and `wr_be[3]`. Offset 3 is bits 7:0 and `wr_be[0]`.
- R4: A byte load at offset k returns the byte in bits (31-8k):(24-8k) of `rd_word` in bits 7:0 of `ld_result`, with bits 31:8 zero, and raises `ld_valid`.
- R5: A halfword load at offset 0 returns `rd_word[31:16]`, and at offset 2 returns `rd_word[15:0]`. The value goes in bits 15:0 of `ld_result` with bits 31:16 zero, and `ld_valid` goes high.
- R6: A word load at offset 0 returns `rd_word` unchanged and raises `ld_valid`.
- R7: A byte store at offset k asserts only `wr_be[3-k]` and drives `st_src[7:0]` on all four lanes of `wr_word`. The upper 24 bits of `st_src` are not written.
- R8: A halfword store asserts `wr_be` = 4'b1100 at offset 0 and 4'b0011 at offset 2. It drives `st_src[15:0]` on both halves of `wr_word`.
- R9: A word store at offset 0 asserts `wr_be` = 4'b1111 and drives `st_src` unchanged.
- R10: A halfword access needs address bit 0 clear, and a word access needs bits 1:0 clear. A misaligned load sets `ld_fault` with `exc_code` = 4, and `ld_valid` and `ld_result` are zero. A misaligned store sets `st_fault` with `exc_code` = 5, and `wr_be` and `wr_word` are zero. `exc_code` is 0 when there is no fault.
- R11: Every output reflects the request sampled at the previous rising clock edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| opcode | input | 6 | Access opcode, instruction bits 31:26 |
| addr_lo | input | 2 | Byte offset inside the word |
| st_src | input | 32 | Store source register value |
| rd_word | input | 32 | Word read from memory for a load |
| wr_be | output | 4 | Byte write enables, bit 3 for the most significant lane |
| wr_word | output | 32 | Lane-aligned store data |
| ld_result | output | 32 | Extended load value |
| ld_valid | output | 1 | Accepted load result present |
| ld_fault | output | 1 | Load alignment fault |
| st_fault | output | 1 | Store alignment fault |
| exc_code | output | 5 | Exception code for the fault (4 load, 5 store, else 0) |

## Verification
The assertions assume the inputs are stable across each rising edge. They also assume the memory word for a load arrives in the same cycle as the load request, because the unit samples both together. The stimulus changes all inputs only on falling edges and presents `rd_word` alongside the opcode. It sweeps every 6-bit opcode at every byte offset with several data patterns, so every legal and illegal opcode and alignment combination lies within those assumptions.

// File: rtl/lslane_pkg.sv
package lslane_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFS_W  = $clog2(LANES);
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned EXC_W  = 5;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_WORD = 2'd3
  } acc_size_t;

  localparam logic [OPC_W-1:0] OP_LD_BYTE_U = 6'h24;
  localparam logic [OPC_W-1:0] OP_LD_HALF_U = 6'h25;
  localparam logic [OPC_W-1:0] OP_LD_WORD   = 6'h23;
  localparam logic [OPC_W-1:0] OP_ST_BYTE   = 6'h28;
  localparam logic [OPC_W-1:0] OP_ST_HALF   = 6'h29;
  localparam logic [OPC_W-1:0] OP_ST_WORD   = 6'h2b;

  localparam logic [EXC_W-1:0] EXC_NONE     = 5'd0;
  localparam logic [EXC_W-1:0] EXC_LD_ALIGN = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ST_ALIGN = 5'd5;
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lslane_pkg::*;
(
  input  logic             valid,
  input  logic [OPC_W-1:0] opcode,
  output acc_size_t        size,
  output logic             is_load,
  output logic             is_store
);
  always_comb begin
    size     = SZ_NONE;
    is_load  = 1'b0;
    is_store = 1'b0;
    if (valid) begin
      case (opcode)
        OP_LD_BYTE_U: begin size = SZ_BYTE; is_load  = 1'b1; end
        OP_LD_HALF_U: begin size = SZ_HALF; is_load  = 1'b1; end
        OP_LD_WORD:   begin size = SZ_WORD; is_load  = 1'b1; end
        OP_ST_BYTE:   begin size = SZ_BYTE; is_store = 1'b1; end
        OP_ST_HALF:   begin size = SZ_HALF; is_store = 1'b1; end
        OP_ST_WORD:   begin size = SZ_WORD; is_store = 1'b1; end
        default:      begin size = SZ_NONE; end
      endcase
    end
  end
endmodule

// File: rtl/lane_align.sv
module lane_align
  import lslane_pkg::*;
(
  input  acc_size_t        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             misaligned
);
  always_comb begin
    unique case (size)
      SZ_HALF: misaligned = ofs[0];
      SZ_WORD: misaligned = |ofs;
      default: misaligned = 1'b0;
    endcase
  end
endmodule

// File: rtl/lane_store.sv
module lane_store
  import lslane_pkg::*;
(
  input  acc_size_t         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WORD_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] wdata
);
  // Lane l carries big-endian byte position LANES-1-l.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFS_W-1:0] POS = OFS_W'(LANES - 1 - l);
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          be[l]          = (POS == ofs);
          wdata[l*8 +: 8] = src[7:0];
        end
        SZ_HALF: begin
          be[l]          = (POS[OFS_W-1:1] == ofs[OFS_W-1:1]);
          wdata[l*8 +: 8] = POS[0] ? src[7:0] : src[15:8];
        end
        SZ_WORD: begin
          be[l]          = 1'b1;
          wdata[l*8 +: 8] = src[l*8 +: 8];
        end
        default: begin
          be[l]          = 1'b0;
          wdata[l*8 +: 8] = 8'h00;
        end
      endcase
    end
  end
endmodule

// File: rtl/lane_load.sv
module lane_load
  import lslane_pkg::*;
(
  input  acc_size_t         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WORD_W-1:0] rd,
  output logic [WORD_W-1:0] result
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  always_comb begin
    byte_sel = 8'h00;
    for (int l = 0; l < LANES; l++) begin
      if (OFS_W'(LANES - 1 - l) == ofs) byte_sel = rd[l*8 +: 8];
    end
  end

  always_comb begin
    half_sel = 16'h0000;
    for (int h = 0; h < LANES / 2; h++) begin
      if ((OFS_W-1)'(LANES / 2 - 1 - h) == ofs[OFS_W-1:1]) half_sel = rd[h*16 +: 16];
    end
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(WORD_W-8){1'b0}}, byte_sel};
      SZ_HALF: result = {{(WORD_W-16){1'b0}}, half_sel};
      SZ_WORD: result = rd;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
  import lslane_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [WORD_W-1:0] st_src,
  input  logic [WORD_W-1:0] rd_word,
  output logic [LANES-1:0]  wr_be,
  output logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] ld_result,
  output logic              ld_valid,
  output logic              ld_fault,
  output logic              st_fault,
  output logic [EXC_W-1:0]  exc_code
);
  acc_size_t         size;
  logic              is_load, is_store, misaligned;
  logic [LANES-1:0]  be_c;
  logic [WORD_W-1:0] wdata_c, ldres_c;
  logic              ld_ok, st_ok, ld_bad, st_bad;

  lane_decode u_dec (
    .valid(req_valid), .opcode(opcode),
    .size(size), .is_load(is_load), .is_store(is_store)
  );

  lane_align u_aln (.size(size), .ofs(addr_lo), .misaligned(misaligned));

  lane_store u_st (
    .size(size), .ofs(addr_lo), .src(st_src), .be(be_c), .wdata(wdata_c)
  );

  lane_load u_ld (.size(size), .ofs(addr_lo), .rd(rd_word), .result(ldres_c));

  assign ld_ok  = is_load  & ~misaligned;
  assign st_ok  = is_store & ~misaligned;
  assign ld_bad = is_load  &  misaligned;
  assign st_bad = is_store &  misaligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_be     <= '0;
      wr_word   <= '0;
      ld_result <= '0;
      ld_valid  <= 1'b0;
      ld_fault  <= 1'b0;
      st_fault  <= 1'b0;
      exc_code  <= EXC_NONE;
    end else begin
      wr_be     <= st_ok ? be_c    : '0;
      wr_word   <= st_ok ? wdata_c : '0;
      ld_result <= ld_ok ? ldres_c : '0;
      ld_valid  <= ld_ok;
      ld_fault  <= ld_bad;
      st_fault  <= st_bad;
      exc_code  <= ld_bad ? EXC_LD_ALIGN : (st_bad ? EXC_ST_ALIGN : EXC_NONE);
    end
  end
endmodule

// File: rtl/be_lane_unit_chk.sv
module be_lane_unit_chk
  import lslane_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic [OFS_W-1:0]  addr_lo,
  input logic [LANES-1:0]  wr_be,
  input logic [WORD_W-1:0] ld_result,
  input logic              ld_valid,
  input logic              ld_fault,
  input logic              st_fault,
  input logic [EXC_W-1:0]  exc_code
);
  // R10: the two fault kinds never coincide
  a_r10_faults_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ld_fault && st_fault));

  // R10: a faulted store touches no lane
  a_r10_fault_no_write: assert property (@(posedge clk) disable iff (rst)
    st_fault |-> (wr_be == '0));

  // R10: exception code follows the fault kind
  a_r10_ld_code: assert property (@(posedge clk) disable iff (rst)
    ld_fault |-> (exc_code == EXC_LD_ALIGN && !ld_valid));
  a_r10_st_code: assert property (@(posedge clk) disable iff (rst)
    st_fault |-> (exc_code == EXC_ST_ALIGN));

  // R7 R8 R9: enable count is 0, 1, 2 or 4
  a_r7_be_shape: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr_be) != 3));

  // R4: an unsigned byte load leaves bits 31:8 clear
  a_r4_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(opcode) == OP_LD_BYTE_U)
      |-> (ld_result[WORD_W-1:8] == '0 && ld_valid));

  // R5: an unsigned halfword load leaves bits 31:16 clear
  a_r5_half_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(opcode) == OP_LD_HALF_U)
      |-> (ld_result[WORD_W-1:16] == '0));

  // R3: a byte store at offset 0 enables only the most significant lane
  a_r3_msb_lane: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(opcode) == OP_ST_BYTE && $past(addr_lo) == '0)
      |-> (wr_be == LANES'(1 << (LANES - 1))));

  // R2: no request means no activity next cycle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_valid))
      |-> (wr_be == '0 && !ld_valid && !ld_fault && !st_fault));
endmodule

bind be_lane_unit be_lane_unit_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .opcode(opcode),
  .addr_lo(addr_lo), .wr_be(wr_be), .ld_result(ld_result),
  .ld_valid(ld_valid), .ld_fault(ld_fault), .st_fault(st_fault),
  .exc_code(exc_code)
);

// File: tb/sim_be_lane_unit.sv
`timescale 1ns/1ps
module sim_be_lane_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [5:0]  opcode;
  logic [1:0]  addr_lo;
  logic [31:0] st_src, rd_word;
  logic [3:0]  wr_be;
  logic [31:0] wr_word, ld_result;
  logic        ld_valid, ld_fault, st_fault;
  logic [4:0]  exc_code;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  be_lane_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .opcode(opcode),
    .addr_lo(addr_lo), .st_src(st_src), .rd_word(rd_word),
    .wr_be(wr_be), .wr_word(wr_word), .ld_result(ld_result),
    .ld_valid(ld_valid), .ld_fault(ld_fault), .st_fault(st_fault),
    .exc_code(exc_code)
  );

  // Expected outputs, computed arithmetically from the requirements.
  logic [3:0]  e_be;
  logic [31:0] e_wd, e_ld;
  logic        e_lv, e_lf, e_sf;
  logic [4:0]  e_ec;
  string       e_req;

  task automatic model(input bit v, input int op, input int off,
                       input logic [31:0] s, input logic [31:0] r);
    bit ld, st, mis;
    int sz;
    e_be = 0; e_wd = 0; e_ld = 0; e_lv = 0; e_lf = 0; e_sf = 0; e_ec = 0;
    e_req = "R2";
    ld = 0; st = 0; sz = 0;
    if (v) begin
      case (op)
        'h24: begin ld = 1; sz = 1; e_req = "R4"; end
        'h25: begin ld = 1; sz = 2; e_req = "R5"; end
        'h23: begin ld = 1; sz = 4; e_req = "R6"; end
        'h28: begin st = 1; sz = 1; e_req = "R7"; end
        'h29: begin st = 1; sz = 2; e_req = "R8"; end
        'h2b: begin st = 1; sz = 4; e_req = "R9"; end
        default: ;
      endcase
    end
    mis = (off % sz_or1(sz)) != 0;
    if ((ld || st) && mis) begin
      e_req = "R10";
      e_lf = ld; e_sf = st; e_ec = ld ? 5'd4 : 5'd5;
    end else if (ld) begin
      e_lv = 1;
      if (sz == 1)      e_ld = (r >> (8 * (3 - off))) & 32'hff;
      else if (sz == 2) e_ld = (r >> (8 * (2 - off))) & 32'hffff;
      else              e_ld = r;
    end else if (st) begin
      if (sz == 1) begin
        e_be = 4'(1 << (3 - off));
        e_wd = (s & 32'hff) * 32'h0101_0101;
      end else if (sz == 2) begin
        e_be = 4'(3 << (2 - off));
        e_wd = (s & 32'hffff) * 32'h0001_0001;
      end else begin
        e_be = 4'hf;
        e_wd = s;
      end
    end
  endtask

  function automatic int sz_or1(input int sz);
    return (sz == 0) ? 1 : sz;
  endfunction

  task automatic compare(input string req);
    n_vec++;
    if (wr_be !== e_be || wr_word !== e_wd || ld_result !== e_ld ||
        ld_valid !== e_lv || ld_fault !== e_lf || st_fault !== e_sf ||
        exc_code !== e_ec) begin
      n_fail++;
      $display("FAIL %s op=%h ofs=%0d actual be=%h wd=%h ld=%h lv=%b lf=%b sf=%b ec=%0d expected be=%h wd=%h ld=%h lv=%b lf=%b sf=%b ec=%0d",
               req, opcode, addr_lo, wr_be, wr_word, ld_result, ld_valid,
               ld_fault, st_fault, exc_code, e_be, e_wd, e_ld, e_lv, e_lf,
               e_sf, e_ec);
    end
  endtask

  task automatic apply(input bit v, input int op, input int off,
                       input logic [31:0] s, input logic [31:0] r);
    req_valid = v; opcode = 6'(op); addr_lo = 2'(off);
    st_src = s; rd_word = r;
    model(v, op, off, s, r);
    @(posedge clk);
    @(negedge clk);
    compare(e_req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the sweep ended");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pats [3];
    pats[0] = 32'hA1B2_C3D4;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h1357_9BDF;

    rst = 1'b1; req_valid = 1'b1; opcode = 6'h2b; addr_lo = 0;
    st_src = 32'hDEAD_BEEF; rd_word = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    // R1: reset holds all outputs at zero despite an active request
    model(1'b0, 0, 0, 0, 0);
    compare("R1");
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1");

    // R3: big-endian lane numbering, directed
    apply(1'b1, 'h24, 0, 32'h0, 32'hA1B2_C3D4);
    if (ld_result !== 32'h0000_00A1) begin
      n_fail++; $display("FAIL R3 byte ofs0 actual %h expected 000000a1", ld_result);
    end
    n_vec++;
    apply(1'b1, 'h28, 3, 32'h0000_0055, 32'h0);
    if (wr_be !== 4'b0001) begin
      n_fail++; $display("FAIL R3 store ofs3 actual %b expected 0001", wr_be);
    end
    n_vec++;

    // R11: outputs hold until the next rising edge
    req_valid = 1'b1; opcode = 6'h2b; addr_lo = 0; st_src = 32'h1234_5678;
    #1;
    n_vec++;
    if (wr_be !== 4'b0001) begin
      n_fail++; $display("FAIL R11 changed before edge actual %b expected 0001", wr_be);
    end
    @(posedge clk); #1;
    n_vec++;
    if (wr_be !== 4'b1111 || wr_word !== 32'h1234_5678) begin
      n_fail++; $display("FAIL R11 after edge actual %b/%h expected 1111/12345678", wr_be, wr_word);
    end
    @(negedge clk);

    // Exhaustive sweep: every opcode, offset and data pattern (R2..R10)
    for (int op = 0; op < 64; op++)
      for (int off = 0; off < 4; off++)
        for (int p = 0; p < 3; p++)
          apply(1'b1, op, off, ~pats[(p + 1) % 3], pats[p]);

    // R2: legal opcodes with req_valid low do nothing
    for (int off = 0; off < 4; off++) begin
      apply(1'b0, 'h2b, off, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      apply(1'b0, 'h25, off, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule